// File: doc/BRIEF.md
# Priority Pin Crossbar with Skip

This block hands a row of port pins to a fixed list of digital peripheral functions. The list runs in a fixed priority order. Each enabled function takes the lowest-numbered pin that is not yet taken and is not marked in a per-pin skip mask, so skipped pins are passed over and left to general-purpose port control. The slave-select line of the SPI is placed only when the SPI runs in 4-wire mode. A single crossbar enable gates everything. While it is low, no pin is owned by a peripheral and every pin output driver is off, so all pins act as inputs.

The pin assignment is worked out combinationally from the configuration inputs and is held in registers. A configuration change therefore shows at the outputs one clock later. The output and input data paths are plain multiplexers steered by the registered assignment. An owned pin drives the value and drive enable of its function. An unowned pin drives the general-purpose latch value and enable. Each function receives the level of its pin. If the enabled functions need more pins than are free, the functions at the end of the order get no pin and a sticky overflow flag is raised.

Top module: `pin_xbar`

## Requirements
- R1: Function indices are UART TX=0, UART RX=1, SPI clock=2, SPI MISO=3, SPI MOSI=4, SPI select=5, comparator A=6, comparator B=7. With the crossbar on, enabled functions take free pins in ascending index order. Pin k of `pinSel` (bits 3k+2:3k) holds the owning index, or 0 when the pin is unowned.
- R2: A pin whose `skipMask` bit is 1 is never owned. The next function takes the next pin whose skip bit is 0.
- R3: Function 5 (SPI select) is given a pin only while `spi4Wire` is 1. While `spi4Wire` is 0 its `funcEn` bit has no effect and uses no pin.
- R4: While `xbarEn` is 0, `pinOwned` is all zero and `outGate` is 0, whatever the `funcEn` bits are.
- R5: While `outGate` is 0, `pinOe` is all zero. This includes pins whose `gpioOe` bit is 1.
- R6: If the enabled functions outnumber the pins with skip bit 0, the functions beyond the last free pin stay unassigned and `overflow` becomes 1. It stays 1 until reset.
- R7: An owned pin drives `funcOut` and `funcOe` of its function. An unowned pin drives `gpioOut` and `gpioOe` of the same pin. The drive enable is ANDed with `outGate`.
- R8: `funcIn[f]` equals `pinIn` of the pin assigned to function f. It is 0 when f has no pin.
- R9: `pinSel`, `pinOwned`, `outGate` and `overflow` follow a change on `xbarEn`, `spi4Wire`, `funcEn` or `skipMask` one clock later. After reset they are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| xbarEn | input | 1 | Global crossbar enable |
| spi4Wire | input | 1 | 1 = SPI select line needs a pin |
| funcEn | input | 8 | Per-function enable, bit = function index |
| skipMask | input | NUM_PINS | 1 = pin excluded from assignment |
| pinIn | input | NUM_PINS | Levels seen on the pins |
| gpioOut | input | NUM_PINS | Port latch output values |
| gpioOe | input | NUM_PINS | Port latch drive enables |
| funcOut | input | 8 | Peripheral output values by function |
| funcOe | input | 8 | Peripheral drive enables by function |
| pinSel | output | 3*NUM_PINS | Owning function index per pin |
| pinOwned | output | NUM_PINS | 1 = pin owned by a peripheral |
| outGate | output | 1 | Global output-driver enable |
| overflow | output | 1 | Sticky: more functions than free pins |
| pinOut | output | NUM_PINS | Value driven per pin |
| pinOe | output | NUM_PINS | Drive enable per pin |
| funcIn | output | 8 | Pin level returned to each function |

## Verification
The assertions compare registered state with the configuration inputs through `$past`. They assume that `xbarEn`, `spi4Wire`, `funcEn` and `skipMask` are stable around each rising edge and are known from the first edge after reset. The stimulus changes configuration and data only a short delay after a rising edge. It holds every input at a defined value from time zero, including during reset. Random configurations are mixed with directed cases that hit the edges: the SPI select line with each wire mode, skip runs at both ends of the row, and more demand than pins. Reset is applied in the middle of a run so that the sticky overflow flag is seen to clear.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int NUM_FUNCS = 8;
  localparam int SEL_W = $clog2(NUM_FUNCS);

  typedef enum logic [SEL_W-1:0] {
    FN_UART_TX = 3'd0,
    FN_UART_RX = 3'd1,
    FN_SPI_CLK = 3'd2,
    FN_SPI_MISO = 3'd3,
    FN_SPI_MOSI = 3'd4,
    FN_SPI_SEL = 3'd5,
    FN_CMP_A = 3'd6,
    FN_CMP_B = 3'd7
  } func_e;

  // strobes from control to datapath that do not scale with the pin count
  typedef struct packed {
    logic gate;
    logic [NUM_FUNCS-1:0] funcValid;
  } xbar_strobe_t;
endpackage

// File: rtl/pin_xbar_ctrl.sv
module pin_xbar_ctrl
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      xbarEn,
  input  logic                      spi4Wire,
  input  logic [NUM_FUNCS-1:0]      funcEn,
  input  logic [NUM_PINS-1:0]       skipMask,
  output xbar_strobe_t              stb,
  output logic [NUM_PINS-1:0]       ownedQ,
  output logic [NUM_PINS*SEL_W-1:0] selQ,
  output logic [NUM_FUNCS*PIN_W-1:0] funcPinQ,
  output logic                      overflowQ
);
  logic [NUM_FUNCS-1:0] needed;
  int pinRank [NUM_PINS];
  int funcRank [NUM_FUNCS];
  int freeCnt;
  int needCnt;
  logic [NUM_PINS-1:0] ownedD;
  logic [NUM_PINS*SEL_W-1:0] selD;
  logic [NUM_FUNCS*PIN_W-1:0] funcPinD;
  logic [NUM_FUNCS-1:0] validD;
  logic overflowD;

  // a function is needed when enabled, the crossbar is on, and for the
  // select line only in 4-wire mode
  always_comb begin
    needed = funcEn & {NUM_FUNCS{xbarEn}};
    if (!spi4Wire) needed[FN_SPI_SEL] = 1'b0;
  end

  // rank of each free pin among free pins, rank of each needed function
  always_comb begin
    freeCnt = 0;
    for (int i = 0; i < NUM_PINS; i++) begin
      pinRank[i] = freeCnt;
      if (!skipMask[i]) freeCnt = freeCnt + 1;
    end
    needCnt = 0;
    for (int f = 0; f < NUM_FUNCS; f++) begin
      funcRank[f] = needCnt;
      if (needed[f]) needCnt = needCnt + 1;
    end
  end

  // the n-th needed function meets the n-th free pin
  always_comb begin
    ownedD = '0;
    selD = '0;
    funcPinD = '0;
    validD = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      for (int f = 0; f < NUM_FUNCS; f++) begin
        if (!skipMask[i] && needed[f] && (pinRank[i] == funcRank[f])) begin
          ownedD[i] = 1'b1;
          selD[i*SEL_W +: SEL_W] = SEL_W'(f);
          funcPinD[f*PIN_W +: PIN_W] = PIN_W'(i);
          validD[f] = 1'b1;
        end
      end
    end
    overflowD = (needCnt > freeCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownedQ <= '0;
      selQ <= '0;
      funcPinQ <= '0;
      stb <= '0;
      overflowQ <= 1'b0;
    end else begin
      ownedQ <= ownedD;
      selQ <= selD;
      funcPinQ <= funcPinD;
      stb.funcValid <= validD;
      stb.gate <= xbarEn;
      overflowQ <= overflowQ | overflowD;
    end
  end

  // one owned pin per assigned function
  assert_pin_count_R1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ownedQ) == $countones(stb.funcValid));

  // a pin skipped at the last edge is never owned
  assert_skip_honoured_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((ownedQ & $past(skipMask)) == '0));

  // select line gets no pin in 3-wire mode
  assert_sel_3wire_R3: assert property (@(posedge clk) disable iff (!rstN)
    !spi4Wire |=> !stb.funcValid[FN_SPI_SEL]);

  // crossbar off leaves every pin unowned
  assert_off_no_owner_R4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.gate |-> (ownedQ == '0));

  // overflow is sticky
  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    overflowQ |=> overflowQ);

  // a function with no pin while the crossbar was on implies overflow
  assert_overflow_raised_R6: assert property (@(posedge clk) disable iff (!rstN)
    (xbarEn && (funcEn[FN_UART_TX] || funcEn[FN_CMP_B])) |=>
      (overflowQ || (stb.funcValid[FN_UART_TX] == $past(funcEn[FN_UART_TX]))));
endmodule

// File: rtl/pin_xbar_datapath.sv
module pin_xbar_datapath
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  xbar_strobe_t               stb,
  input  logic [NUM_PINS-1:0]        ownedQ,
  input  logic [NUM_PINS*SEL_W-1:0]  selQ,
  input  logic [NUM_FUNCS*PIN_W-1:0] funcPinQ,
  input  logic [NUM_PINS-1:0]        pinIn,
  input  logic [NUM_PINS-1:0]        gpioOut,
  input  logic [NUM_PINS-1:0]        gpioOe,
  input  logic [NUM_FUNCS-1:0]       funcOut,
  input  logic [NUM_FUNCS-1:0]       funcOe,
  output logic [NUM_PINS-1:0]        pinOut,
  output logic [NUM_PINS-1:0]        pinOe,
  output logic [NUM_FUNCS-1:0]       funcIn
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [SEL_W-1:0] sel;
    assign sel = selQ[i*SEL_W +: SEL_W];
    always_comb begin
      if (ownedQ[i]) begin
        pinOut[i] = funcOut[sel];
        pinOe[i] = stb.gate & funcOe[sel];
      end else begin
        pinOut[i] = gpioOut[i];
        pinOe[i] = stb.gate & gpioOe[i];
      end
    end
  end

  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_func
    logic [PIN_W-1:0] src;
    assign src = funcPinQ[f*PIN_W +: PIN_W];
    assign funcIn[f] = stb.funcValid[f] & pinIn[src];
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      xbarEn,
  input  logic                      spi4Wire,
  input  logic [7:0]                funcEn,
  input  logic [NUM_PINS-1:0]       skipMask,
  input  logic [NUM_PINS-1:0]       pinIn,
  input  logic [NUM_PINS-1:0]       gpioOut,
  input  logic [NUM_PINS-1:0]       gpioOe,
  input  logic [7:0]                funcOut,
  input  logic [7:0]                funcOe,
  output logic [NUM_PINS*3-1:0]     pinSel,
  output logic [NUM_PINS-1:0]       pinOwned,
  output logic                      outGate,
  output logic                      overflow,
  output logic [NUM_PINS-1:0]       pinOut,
  output logic [NUM_PINS-1:0]       pinOe,
  output logic [7:0]                funcIn
);
  localparam int PIN_W = $clog2(NUM_PINS);

  xbar_strobe_t stb;
  logic [NUM_FUNCS*PIN_W-1:0] funcPinQ;

  pin_xbar_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk(clk), .rstN(rstN), .xbarEn(xbarEn), .spi4Wire(spi4Wire),
    .funcEn(funcEn), .skipMask(skipMask), .stb(stb), .ownedQ(pinOwned),
    .selQ(pinSel), .funcPinQ(funcPinQ), .overflowQ(overflow)
  );

  pin_xbar_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .stb(stb), .ownedQ(pinOwned), .selQ(pinSel), .funcPinQ(funcPinQ),
    .pinIn(pinIn), .gpioOut(gpioOut), .gpioOe(gpioOe), .funcOut(funcOut),
    .funcOe(funcOe), .pinOut(pinOut), .pinOe(pinOe), .funcIn(funcIn)
  );

  assign outGate = stb.gate;

  // gate low forces every driver off at the pins
  assert_gate_drivers_R5: assert property (@(posedge clk) disable iff (!rstN)
    !outGate |-> (pinOe == '0));
endmodule

// File: tb/pin_xbar_tb.sv
module pin_xbar_tb;
  localparam int NP = 8;
  localparam int NF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xbarEn = 1'b0, spi4Wire = 1'b0;
  logic [NF-1:0] funcEn = '0, funcOut = '0, funcOe = '0;
  logic [NP-1:0] skipMask = '0, pinIn = '0, gpioOut = '0, gpioOe = '0;
  logic [NP*3-1:0] pinSel;
  logic [NP-1:0] pinOwned, pinOut, pinOe;
  logic [NF-1:0] funcIn;
  logic outGate, overflow;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_xbar #(.NUM_PINS(NP)) u_dut (.*);

  // behavioural reference: walk the pins with a cursor
  logic [NP-1:0] expOwned;
  int expSel [NP];
  int expPin [NF];
  logic [NF-1:0] expValid;
  logic expGate, expOv;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expOwned = '0; expValid = '0; expGate = 0; expOv = 0;
      for (int i = 0; i < NP; i++) expSel[i] = 0;
      for (int f = 0; f < NF; f++) expPin[f] = 0;
    end else begin
      int cur;
      cur = 0;
      expOwned = '0; expValid = '0;
      for (int i = 0; i < NP; i++) expSel[i] = 0;
      for (int f = 0; f < NF; f++) begin
        bit want;
        expPin[f] = 0;
        want = xbarEn && funcEn[f] && (f != 5 || spi4Wire);
        if (want) begin
          while (cur < NP && skipMask[cur]) cur++;
          if (cur < NP) begin
            expOwned[cur] = 1; expSel[cur] = f; expPin[f] = cur;
            expValid[f] = 1; cur++;
          end else expOv = 1;
        end
      end
      expGate = xbarEn;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    logic [NP*3-1:0] eSel;
    logic [NP-1:0] eOut, eOe;
    logic [NF-1:0] eIn;
    for (int i = 0; i < NP; i++) begin
      eSel[i*3 +: 3] = 3'(expSel[i]);
      eOut[i] = expOwned[i] ? funcOut[expSel[i]] : gpioOut[i];
      eOe[i] = expGate & (expOwned[i] ? funcOe[expSel[i]] : gpioOe[i]);
    end
    for (int f = 0; f < NF; f++) eIn[f] = expValid[f] & pinIn[expPin[f]];
    chk("R1", "pinSel", pinSel, eSel);          // priority order, R3 select line, R9 timing
    chk("R2", "pinOwned", pinOwned, expOwned);  // skip handling, R4 off state
    chk("R4", "outGate", outGate, expGate);
    chk("R6", "overflow", overflow, expOv);
    chk("R7", "pinOut", pinOut, eOut);
    chk("R5", "pinOe", pinOe, eOe);
    chk("R8", "funcIn", funcIn, eIn);
  end

  task automatic cfg(bit en, bit w4, logic [NF-1:0] fe, logic [NP-1:0] sk, int hold);
    for (int c = 0; c < hold; c++) begin
      @(posedge clk); #2;
      xbarEn = en; spi4Wire = w4; funcEn = fe; skipMask = sk;
      pinIn = NP'($urandom); gpioOut = NP'($urandom); gpioOe = NP'($urandom);
      funcOut = NF'($urandom); funcOe = NF'($urandom);
    end
  endtask

  task automatic pulseReset();
    @(posedge clk); #2; rstN = 0;
    @(posedge clk); #2; rstN = 1;
  endtask

  initial begin
    cfg(1, 1, 8'hFF, '0, 3);                   // R9 reset state while config active
    @(posedge clk); #2; rstN = 1;
    cfg(0, 1, 8'hFF, '0, 4);                   // R4 and R5 crossbar off
    cfg(1, 0, 8'hFF, '0, 4);                   // R3 3-wire: 7 functions
    cfg(1, 1, 8'hFF, '0, 4);                   // R1 all 8 functions
    cfg(1, 0, 8'h7F, 8'b1000_0101, 4);         // R2 skips at both ends
    cfg(1, 1, 8'hFF, 8'b0010_0000, 4);         // R6 overflow
    cfg(1, 0, 8'h03, '0, 4);                   // R6 still set
    pulseReset();                              // R6 cleared by reset
    cfg(1, 1, 8'hE4, 8'b0101_0101, 4);
    for (int k = 0; k < 300; k++) begin
      cfg($urandom_range(0, 5) != 0, 1'($urandom), NF'($urandom),
          ($urandom_range(0, 2) == 0) ? NP'($urandom) : '0, $urandom_range(1, 4));
      if (k == 150) pulseReset();
    end
    @(posedge clk); @(negedge clk); #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL R9 watchdog expired: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule